// File: doc/BRIEF.md
# CPU Interrupt Entry Controller

This block sits next to a small 8-bit processor core and decides, at each instruction boundary, whether the core runs the instruction it has just fetched or starts a service routine. It watches three request sources. The first is an active-low reset. The second is a non-maskable request that is active low and acts on its falling edge. The third is a maskable request that is active low, acts on its level, and is gated by a mask flag that this block holds.

When a hardware source wins, the block replaces the fetched opcode with the break opcode (0x00) and tells the core not to advance the program counter. It also presents the low-byte address of the winning source's vector; the core reads the high byte from the following address. When the fetched opcode is itself the break opcode and no hardware source wins, the block starts a software break. A software break uses the maskable vector, advances the PC by two and raises a break status bit. The core drives the mask flag through set and clear strobes, and every service entry sets the flag.

The core pulses `atBoundary` for one clock while `fetchedOp` holds the newly fetched opcode. The block registers its decision on that clock edge.

Top module: `intEntryTop`

## Requirements
- R1: While `rstN` is low, `haltCore` is 1, `serviceStart` is 0 and `maskFlag` is 1, and `opcodeOut`, `pcStep`, `pcIncInhibit` and `breakFlag` read 0. After release, the first boundary starts a reset service with vector 0xFFFC.
- R2: When sources are pending together, reset wins, then the non-maskable request, then the maskable request, then a fetched break opcode. A source that loses stays pending for a later boundary.
- R3: A falling edge on `nmiN` gives exactly one service. Holding the line low gives no further service, and a new service needs the line to go high and then fall again.
- R4: The non-maskable request is taken while `maskFlag` is 1. Its vector is 0xFFFA.
- R5: While `irqN` is low and `maskFlag` is 0, a boundary starts a maskable service with vector 0xFFFE. This repeats for as long as the line stays low and the mask is cleared again.
- R6: A low pulse on `irqN` that ends while `maskFlag` is 1 is lost. Clearing the mask afterwards starts no service.
- R7: If `irqN` is still low when the mask is cleared, the next boundary starts the maskable service.
- R8: Every service entry sets `maskFlag`. `maskSetReq` sets the flag and `maskClrReq` clears it. A maskable line that stays low does not re-enter while the flag is set.
- R9: A hardware entry (reset, non-maskable or maskable) gives `opcodeOut`=0x00, `pcIncInhibit`=1, `pcStep`=0 and `breakFlag`=0.
- R10: A fetched opcode 0x00 with no hardware source winning starts a software break, whatever the mask. It gives vector 0xFFFE, `breakFlag`=1, `pcStep`=2 and `pcIncInhibit`=0.
- R11: A boundary with no service passes `fetchedOp` to `opcodeOut` with `pcStep`=1, `pcIncInhibit`=0 and `breakFlag`=0.
- R12: A non-maskable edge that arrives while another source is pending stays latched until its own service starts.
- R13: `serviceStart` is a one-clock pulse in the clock after the boundary edge. The other entry outputs hold until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset request, also the block reset |
| irqN | input | 1 | Maskable request, active low, level |
| nmiN | input | 1 | Non-maskable request, active low, falling edge |
| maskSetReq | input | 1 | Core strobe that sets the mask flag |
| maskClrReq | input | 1 | Core strobe that clears the mask flag |
| atBoundary | input | 1 | Core is at an instruction boundary |
| fetchedOp | input | 8 | Opcode fetched at this boundary |
| haltCore | output | 1 | Core must stall |
| maskFlag | output | 1 | Current mask flag |
| serviceStart | output | 1 | Pulse: a service entry begins |
| opcodeOut | output | 8 | Opcode the core latches |
| pcIncInhibit | output | 1 | Core must not advance the PC |
| pcStep | output | 2 | PC advance for this instruction |
| breakFlag | output | 1 | Entry came from a software break |
| vectorAddr | output | 16 | Low-byte address of the service vector |

## Verification
A change on `irqN` reaches the decision two clocks after it is driven, which is the synchronizer depth. A falling edge on `nmiN` needs one clock more, because the edge compare adds a register. The bench therefore holds every line change for five clocks before it pulses a boundary. The entry outputs are due in the clock that follows the boundary edge, so the bench reads them at the next falling edge, and it reads the mask flag in that same clock. The single-pulse check on `serviceStart` samples one falling edge later with no boundary applied.

// File: rtl/intEntryPkg.sv
package intEntryPkg;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_RESET = 3'd1,
    SRC_NMI   = 3'd2,
    SRC_IRQ   = 3'd3,
    SRC_BRK   = 3'd4
  } srcSel_e;

  // Strobes from the arbiter to the state/datapath
  typedef struct packed {
    logic    loadEntry;
    srcSel_e src;
    logic    clrNmi;
    logic    clrRst;
    logic    setMask;
  } entryStrobes_t;

endpackage

// File: rtl/intLevelSync.sv
module intLevelSync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  generate
    if (DEPTH <= 1) begin : g_single
      logic stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= 1'b0;
        else       stage <= din;
      end
      assign dout = stage;
    end else begin : g_chain
      logic [DEPTH-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[DEPTH-2:0], din};
      end
      assign dout = chain[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/intEntryCtrl.sv
module intEntryCtrl
  import intEntryPkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter logic [DATA_W-1:0] BRK_OPCODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              atBoundary,
  input  logic [DATA_W-1:0] fetchedOp,
  input  logic              rstPending,
  input  logic              nmiPending,
  input  logic              irqActive,
  input  logic              maskFlag,
  output entryStrobes_t     strb
);

  srcSel_e winner;

  // Fixed priority: reset, non-maskable, maskable, software break
  always_comb begin
    winner = SRC_NONE;
    if (rstPending)                   winner = SRC_RESET;
    else if (nmiPending)              winner = SRC_NMI;
    else if (irqActive && !maskFlag)  winner = SRC_IRQ;
    else if (fetchedOp == BRK_OPCODE) winner = SRC_BRK;
  end

  always_comb begin
    strb.loadEntry = atBoundary;
    strb.src       = winner;
    strb.clrNmi    = atBoundary && (winner == SRC_NMI);
    strb.clrRst    = atBoundary && (winner == SRC_RESET);
    strb.setMask   = atBoundary && (winner != SRC_NONE);
  end

  // R2: a pending non-maskable request never loses to the maskable one
  p_nmi_over_irq_r2: assert property (@(posedge clk) disable iff (!rstN)
    (atBoundary && nmiPending && !rstPending) |-> strb.clrNmi)
    else $error("non-maskable request lost arbitration");

endmodule

// File: rtl/intEntryPath.sv
module intEntryPath
  import intEntryPkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 16,
  parameter int                SYNC_DEPTH = 2,
  parameter logic [DATA_W-1:0] BRK_OPCODE = '0,
  parameter logic [ADDR_W-1:0] NMI_VEC    = 16'hFFFA,
  parameter logic [ADDR_W-1:0] RST_VEC    = 16'hFFFC,
  parameter logic [ADDR_W-1:0] IRQ_VEC    = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqN,
  input  logic              nmiN,
  input  logic              maskSetReq,
  input  logic              maskClrReq,
  input  logic [DATA_W-1:0] fetchedOp,
  input  entryStrobes_t     strb,
  output logic              rstPending,
  output logic              nmiPending,
  output logic              irqActive,
  output logic              maskFlag,
  output logic              serviceStart,
  output logic [DATA_W-1:0] opcodeOut,
  output logic              pcIncInhibit,
  output logic [1:0]        pcStep,
  output logic              breakFlag,
  output logic [ADDR_W-1:0] vectorAddr
);

  localparam logic [1:0] STEP_HOLD   = 2'd0;
  localparam logic [1:0] STEP_NORMAL = 2'd1;
  localparam logic [1:0] STEP_BREAK  = 2'd2;

  logic nmiLow;
  logic nmiLowPrev;
  logic nmiEdge;
  logic isService;
  logic isHardware;

  intLevelSync #(.DEPTH(SYNC_DEPTH)) uIrqSync (
    .clk(clk), .rstN(rstN), .din(~irqN), .dout(irqActive));

  intLevelSync #(.DEPTH(SYNC_DEPTH)) uNmiSync (
    .clk(clk), .rstN(rstN), .din(~nmiN), .dout(nmiLow));

  assign nmiEdge    = nmiLow && !nmiLowPrev;
  assign isService  = strb.loadEntry && (strb.src != SRC_NONE);
  assign isHardware = (strb.src == SRC_RESET) || (strb.src == SRC_NMI) ||
                      (strb.src == SRC_IRQ);

  function automatic logic [ADDR_W-1:0] vecFor(input srcSel_e s);
    case (s)
      SRC_RESET: vecFor = RST_VEC;
      SRC_NMI:   vecFor = NMI_VEC;
      default:   vecFor = IRQ_VEC;
    endcase
  endfunction

  // Request state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiLowPrev <= 1'b0;
      nmiPending <= 1'b0;
      rstPending <= 1'b1;
      maskFlag   <= 1'b1;
    end else begin
      nmiLowPrev <= nmiLow;
      if (nmiEdge)          nmiPending <= 1'b1;
      else if (strb.clrNmi) nmiPending <= 1'b0;
      if (strb.clrRst)      rstPending <= 1'b0;
      if (strb.setMask)     maskFlag   <= 1'b1;
      else if (maskSetReq)  maskFlag   <= 1'b1;
      else if (maskClrReq)  maskFlag   <= 1'b0;
    end
  end

  // Entry outputs, loaded at each boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serviceStart <= 1'b0;
      opcodeOut    <= '0;
      pcIncInhibit <= 1'b0;
      pcStep       <= STEP_HOLD;
      breakFlag    <= 1'b0;
      vectorAddr   <= '0;
    end else begin
      serviceStart <= isService;
      if (strb.loadEntry) begin
        opcodeOut    <= isService ? BRK_OPCODE : fetchedOp;
        pcIncInhibit <= isHardware;
        breakFlag    <= (strb.src == SRC_BRK);
        if (!isService)             pcStep <= STEP_NORMAL;
        else if (isHardware)        pcStep <= STEP_HOLD;
        else                        pcStep <= STEP_BREAK;
        if (isService) vectorAddr <= vecFor(strb.src);
      end
    end
  end

  // R1: the first boundary after release enters the reset vector
  p_reset_entry_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEntry && rstPending) |=> (serviceStart && vectorAddr == RST_VEC))
    else $error("reset service not entered");

  // R3: acknowledging the edge latch clears it unless a new edge arrives
  p_nmi_once_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrNmi && !nmiEdge) |=> !nmiPending)
    else $error("non-maskable latch not cleared");

  // R12: a latched edge survives until its own service
  p_nmi_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPending && !strb.clrNmi) |=> nmiPending)
    else $error("pending non-maskable edge dropped");

  // R8: every entry leaves the mask set
  p_entry_masks_r8: assert property (@(posedge clk) disable iff (!rstN)
    serviceStart |-> maskFlag)
    else $error("mask not set on entry");

  // R9: hardware entry forces the break opcode and holds the PC
  p_hw_force_r9: assert property (@(posedge clk) disable iff (!rstN)
    (serviceStart && !breakFlag) |-> (opcodeOut == BRK_OPCODE && pcIncInhibit &&
                                      pcStep == STEP_HOLD))
    else $error("hardware entry outputs wrong");

  // R10: software break steps the PC by two through the maskable vector
  p_brk_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (serviceStart && breakFlag) |-> (pcStep == STEP_BREAK && !pcIncInhibit &&
                                     vectorAddr == IRQ_VEC))
    else $error("software break outputs wrong");

  // R13: a start pulse only follows a boundary
  p_start_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    serviceStart |-> $past(strb.loadEntry))
    else $error("start pulse without boundary");

endmodule

// File: rtl/intEntryTop.sv
module intEntryTop
  import intEntryPkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 16,
  parameter int                SYNC_DEPTH = 2,
  parameter logic [DATA_W-1:0] BRK_OPCODE = '0,
  parameter logic [ADDR_W-1:0] NMI_VEC    = 16'hFFFA,
  parameter logic [ADDR_W-1:0] RST_VEC    = 16'hFFFC,
  parameter logic [ADDR_W-1:0] IRQ_VEC    = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqN,
  input  logic              nmiN,
  input  logic              maskSetReq,
  input  logic              maskClrReq,
  input  logic              atBoundary,
  input  logic [DATA_W-1:0] fetchedOp,
  output logic              haltCore,
  output logic              maskFlag,
  output logic              serviceStart,
  output logic [DATA_W-1:0] opcodeOut,
  output logic              pcIncInhibit,
  output logic [1:0]        pcStep,
  output logic              breakFlag,
  output logic [ADDR_W-1:0] vectorAddr
);

  entryStrobes_t strb;
  logic rstPending;
  logic nmiPending;
  logic irqActive;

  assign haltCore = ~rstN;

  intEntryCtrl #(.DATA_W(DATA_W), .BRK_OPCODE(BRK_OPCODE)) uCtrl (
    .clk(clk), .rstN(rstN), .atBoundary(atBoundary), .fetchedOp(fetchedOp),
    .rstPending(rstPending), .nmiPending(nmiPending), .irqActive(irqActive),
    .maskFlag(maskFlag), .strb(strb));

  intEntryPath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_DEPTH(SYNC_DEPTH),
    .BRK_OPCODE(BRK_OPCODE), .NMI_VEC(NMI_VEC), .RST_VEC(RST_VEC),
    .IRQ_VEC(IRQ_VEC)
  ) uPath (
    .clk(clk), .rstN(rstN), .irqN(irqN), .nmiN(nmiN),
    .maskSetReq(maskSetReq), .maskClrReq(maskClrReq), .fetchedOp(fetchedOp),
    .strb(strb), .rstPending(rstPending), .nmiPending(nmiPending),
    .irqActive(irqActive), .maskFlag(maskFlag), .serviceStart(serviceStart),
    .opcodeOut(opcodeOut), .pcIncInhibit(pcIncInhibit), .pcStep(pcStep),
    .breakFlag(breakFlag), .vectorAddr(vectorAddr));

endmodule

// File: tb/tb_intEntryTop.sv
module tb_intEntryTop;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 5;
  localparam int LIMIT      = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqN = 1'b1;
  logic nmiN = 1'b1;
  logic maskSetReq = 1'b0;
  logic maskClrReq = 1'b0;
  logic atBoundary = 1'b0;
  logic [7:0] fetchedOp = 8'hEA;
  logic haltCore, maskFlag, serviceStart, pcIncInhibit, breakFlag;
  logic [7:0] opcodeOut;
  logic [1:0] pcStep;
  logic [15:0] vectorAddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  intEntryTop dut (
    .clk(clk), .rstN(rstN), .irqN(irqN), .nmiN(nmiN),
    .maskSetReq(maskSetReq), .maskClrReq(maskClrReq),
    .atBoundary(atBoundary), .fetchedOp(fetchedOp),
    .haltCore(haltCore), .maskFlag(maskFlag), .serviceStart(serviceStart),
    .opcodeOut(opcodeOut), .pcIncInhibit(pcIncInhibit), .pcStep(pcStep),
    .breakFlag(breakFlag), .vectorAddr(vectorAddr));

  always #(CLK_PERIOD/2) clk = ~clk;

  // row: line levels, mask command (1 clear, 2 set), opcode, expected entry
  typedef struct packed {
    logic        irqL;
    logic        nmiL;
    logic [1:0]  cmd;
    logic [7:0]  op;
    logic        svc;
    logic [15:0] vec;
    logic        brk;
    logic [1:0]  step;
    logic        inh;
    logic [3:0]  req;
  } row_t;

  localparam int NROWS = 15;
  localparam row_t ROWS [NROWS] = '{
    '{1'b1, 1'b1, 2'd0, 8'hA9, 1'b1, 16'hFFFC, 1'b0, 2'd0, 1'b1, 4'd1},  // R1
    '{1'b1, 1'b1, 2'd0, 8'hA9, 1'b0, 16'h0000, 1'b0, 2'd1, 1'b0, 4'd11}, // R11
    '{1'b0, 1'b1, 2'd0, 8'hEA, 1'b0, 16'h0000, 1'b0, 2'd1, 1'b0, 4'd8},  // R8
    '{1'b0, 1'b1, 2'd1, 8'hEA, 1'b1, 16'hFFFE, 1'b0, 2'd0, 1'b1, 4'd7},  // R7
    '{1'b0, 1'b1, 2'd0, 8'hEA, 1'b0, 16'h0000, 1'b0, 2'd1, 1'b0, 4'd8},  // R8
    '{1'b0, 1'b1, 2'd1, 8'hEA, 1'b1, 16'hFFFE, 1'b0, 2'd0, 1'b1, 4'd5},  // R5
    '{1'b1, 1'b1, 2'd1, 8'h00, 1'b1, 16'hFFFE, 1'b1, 2'd2, 1'b0, 4'd10}, // R10
    '{1'b1, 1'b1, 2'd0, 8'h00, 1'b1, 16'hFFFE, 1'b1, 2'd2, 1'b0, 4'd10}, // R10
    '{1'b1, 1'b0, 2'd0, 8'hEA, 1'b1, 16'hFFFA, 1'b0, 2'd0, 1'b1, 4'd4},  // R4
    '{1'b1, 1'b0, 2'd0, 8'hEA, 1'b0, 16'h0000, 1'b0, 2'd1, 1'b0, 4'd3},  // R3
    '{1'b1, 1'b1, 2'd0, 8'hEA, 1'b0, 16'h0000, 1'b0, 2'd1, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b0, 2'd1, 8'hEA, 1'b1, 16'hFFFA, 1'b0, 2'd0, 1'b1, 4'd2},  // R2
    '{1'b0, 1'b0, 2'd1, 8'hEA, 1'b1, 16'hFFFE, 1'b0, 2'd0, 1'b1, 4'd2},  // R2
    '{1'b1, 1'b1, 2'd0, 8'h00, 1'b1, 16'hFFFE, 1'b1, 2'd2, 1'b0, 4'd10}, // R10
    '{1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 16'hFFFA, 1'b0, 2'd0, 1'b1, 4'd9}   // R9
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseMask(input logic [1:0] cmd);
    @(negedge clk);
    maskClrReq = (cmd == 2'd1);
    maskSetReq = (cmd == 2'd2);
    @(negedge clk);
    maskClrReq = 1'b0;
    maskSetReq = 1'b0;
  endtask

  // Boundary pulse; outputs are read at the falling edge after the load edge
  task automatic boundary(input logic [7:0] op);
    @(negedge clk);
    atBoundary = 1'b1;
    fetchedOp  = op;
    @(posedge clk);
    @(negedge clk);
    atBoundary = 1'b0;
  endtask

  task automatic checkEntry(input string tag, input logic svc, input logic [7:0] op,
                            input logic [15:0] vec, input logic brk,
                            input logic [1:0] step, input logic inh);
    check({tag, " serviceStart"}, 32'(serviceStart), 32'(svc));
    check({tag, " opcodeOut"}, 32'(opcodeOut), svc ? 32'h0 : 32'(op));
    check({tag, " pcStep"}, 32'(pcStep), 32'(step));
    check({tag, " pcIncInhibit"}, 32'(pcIncInhibit), 32'(inh));
    check({tag, " breakFlag"}, 32'(breakFlag), 32'(brk));
    if (svc) begin
      check({tag, " vectorAddr"}, 32'(vectorAddr), 32'(vec));
      check({tag, " maskFlag after entry R8"}, 32'(maskFlag), 32'h1);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog got %0d cycles expected under %0d", cycles, LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: state while reset is held, including a boundary during reset
    waitCycles(3);
    check("R1 haltCore", 32'(haltCore), 32'h1);
    check("R1 maskFlag", 32'(maskFlag), 32'h1);
    check("R1 opcodeOut", 32'(opcodeOut), 32'h0);
    check("R1 pcStep", 32'(pcStep), 32'h0);
    boundary(8'hA9);
    check("R1 no start in reset", 32'(serviceStart), 32'h0);
    @(negedge clk) rstN = 1'b1;
    waitCycles(1);
    check("R1 haltCore released", 32'(haltCore), 32'h0);

    for (int r = 0; r < NROWS; r++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", ROWS[r].req, r);
      irqN = ROWS[r].irqL;
      nmiN = ROWS[r].nmiL;
      if (ROWS[r].cmd != 2'd0) pulseMask(ROWS[r].cmd);
      waitCycles(SETTLE);
      boundary(ROWS[r].op);
      checkEntry(tag, ROWS[r].svc, ROWS[r].op, ROWS[r].vec,
                 ROWS[r].brk, ROWS[r].step, ROWS[r].inh);
    end

    // R13: start pulse lasts one clock, other outputs hold
    waitCycles(1);
    check("R13 start pulse ends", 32'(serviceStart), 32'h0);
    check("R13 vector held", 32'(vectorAddr), 32'hFFFA);

    // R6: a maskable pulse that ends while masked is lost
    irqN = 1'b0;
    waitCycles(4);
    irqN = 1'b1;
    waitCycles(SETTLE);
    pulseMask(2'd1);
    waitCycles(3);
    boundary(8'hEA);
    checkEntry("R6 lost pulse", 1'b0, 8'hEA, 16'h0, 1'b0, 2'd1, 1'b0);

    // R8: the set strobe masks a low line
    irqN = 1'b0;
    pulseMask(2'd2);
    waitCycles(SETTLE);
    check("R8 set strobe", 32'(maskFlag), 32'h1);
    boundary(8'hEA);
    checkEntry("R8 masked by set", 1'b0, 8'hEA, 16'h0, 1'b0, 2'd1, 1'b0);
    pulseMask(2'd1);
    check("R8 clear strobe", 32'(maskFlag), 32'h0);
    boundary(8'hEA);
    checkEntry("R7 taken after clear", 1'b1, 8'hEA, 16'hFFFE, 1'b0, 2'd0, 1'b1);
    irqN = 1'b1;

    // R12: an edge arriving while reset is pending waits its turn
    nmiN = 1'b1;
    waitCycles(SETTLE);
    @(negedge clk) rstN = 1'b0;
    waitCycles(2);
    @(negedge clk) rstN = 1'b1;
    nmiN = 1'b0;
    waitCycles(SETTLE);
    boundary(8'hEA);
    checkEntry("R2 reset before edge", 1'b1, 8'hEA, 16'hFFFC, 1'b0, 2'd0, 1'b1);
    boundary(8'hEA);
    checkEntry("R12 edge kept", 1'b1, 8'hEA, 16'hFFFA, 1'b0, 2'd0, 1'b1);
    boundary(8'hEA);
    checkEntry("R3 no repeat", 1'b0, 8'hEA, 16'h0, 1'b0, 2'd1, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule